// File: doc/BRIEF.md
# Serial Controller Status Readback

This block is the read side of the register file of a two-channel serial communications controller. A host selects a channel and one of eight read locations with a 3-bit address, then pulses a read strobe. On the next clock edge the block loads the selected byte into a registered 8-bit output. That output keeps its value until the next strobe.

The eight locations serve several purposes:
- Two per-channel status bytes.
- A per-channel interrupt vector.
- One interrupt-pending summary that is shared by both channels.
- Two locations that can either mirror write-side register values or alias the status bytes.
- Two locations that expose a frame-status queue, or alias the vector and pending summary when the queue is off.

Frame producers push received-frame byte counts into the queue through a one-cycle push strobe. The queue records an overflow when a push is lost. Software drains it by reading the high part, then the low part, then the second status byte. The last of those three reads retires the head entry.

Top module: `serial_status_readback`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `rdData` to 0x00, empties the frame queue and clears its overflow flag.
- R2: `rdData` is loaded only at a clock edge where `rdStrobe` is high. At every other edge it keeps its value, whatever the other inputs do.
- R3: Address 3 is the interrupt-pending summary: `{2'b00, irqPend[5:0]}`. The bits of `irqPend` are:
  - bit0: channel B external/status
  - bit1: channel B transmit
  - bit2: channel B receive
  - bit3: channel A external/status
  - bit4: channel A transmit
  - bit5: channel A receive

  With `chanSel`=1 (channel B) address 3 reads 0x00.
- R4: Addresses 0, 1 and 2 return, for the selected channel (`chanSel`=0 is A, 1 is B), the first status byte, the second status byte and the interrupt vector respectively.
- R5: With `extReadEn` high, address 4 returns that channel's write-register-4 value and address 5 returns its write-register-5 value. With `extReadEn` low, address 4 aliases address 0 and address 5 aliases address 1.
- R6: With `fifoEn` high, address 6 returns bits 7:0 of the head entry's byte count. With `fifoEn` low, it aliases address 2 of the same channel.
- R7: With `fifoEn` high, address 7 returns:
  - bit7: overflow flag
  - bit6: data-available (queue not empty)
  - bits 5:0: byte-count bits 13:8 of the head entry

  With `fifoEn` low, address 7 aliases address 3 of the same channel, so it reads 0x00 for channel B.
- R8: A read of address 1 while `fifoEn` is high and the queue is not empty removes the head entry. Reads of addresses 6 and 7 leave the queue unchanged. Entries leave in push order, so the read sequence 7, 6, 1 returns one consistent entry.
- R9: A push (`pushValid` high with `fifoEn` high) into a full queue, with no pop at the same edge, is dropped and sets a sticky overflow flag.
- R10: While `fifoEn` is low, the queue is emptied, the overflow flag is cleared and pushes are ignored.
- R11: When the queue is empty, the byte-count fields read as zero and data-available reads 0.
- R12: A push and a pop at the same edge on a full queue both take effect. The queue stays full, the new entry lands at the tail and no overflow is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rdStrobe | input | 1 | Read request for this cycle |
| chanSel | input | 1 | Channel select, 0 = A, 1 = B |
| rdAddr | input | 3 | Read location |
| extReadEn | input | 1 | Mirror write registers 4 and 5 on addresses 4 and 5 |
| fifoEn | input | 1 | Frame-status queue enable |
| stat0A | input | 8 | Channel A first status byte |
| stat0B | input | 8 | Channel B first status byte |
| stat1A | input | 8 | Channel A second status byte |
| stat1B | input | 8 | Channel B second status byte |
| vecA | input | 8 | Channel A interrupt vector |
| vecB | input | 8 | Channel B (modified) interrupt vector |
| wr4A | input | 8 | Channel A write-register-4 value |
| wr4B | input | 8 | Channel B write-register-4 value |
| wr5A | input | 8 | Channel A write-register-5 value |
| wr5B | input | 8 | Channel B write-register-5 value |
| irqPend | input | 6 | Interrupt-pending sources (mapping in R3) |
| pushValid | input | 1 | Push a frame entry this cycle |
| pushCount | input | CNT_W (14) | Frame byte count to push |
| rdData | output | 8 | Registered read data |

## Verification
The bench builds the block with a queue depth of 4 and the default 14-bit count. This makes the full, overflow and wrap-around cases reachable within a handful of pushes. It sweeps every combination of channel, address, extended-read enable and queue enable. Expected bytes come from an arithmetic model of the aliasing rules and a queue model, and reads of address 1 retire entries as they go. Directed sequences then cover overflow, the simultaneous push and pop at full, flushing on disable and reads from an empty queue.

// File: rtl/rdbk_pkg.sv
package rdbk_pkg;

  localparam int IDX_W = 8;

  typedef enum logic [2:0] {
    SEL_STAT0,
    SEL_STAT1,
    SEL_VEC,
    SEL_PEND,
    SEL_WR4,
    SEL_WR5,
    SEL_CNT_LO,
    SEL_CNT_HI
  } outSel_t;

  typedef struct packed {
    logic             loadOut;
    outSel_t          sel;
    logic             useChanB;
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdx;
    logic             headValid;
    logic             ovfl;
  } strobe_t;

endpackage

// File: rtl/rdbk_ctrl.sv
module rdbk_ctrl #(
  parameter int DEPTH = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdStrobe,
  input  logic              chanSel,
  input  logic [2:0]        rdAddr,
  input  logic              extReadEn,
  input  logic              fifoEn,
  input  logic              pushValid,
  output rdbk_pkg::strobe_t strb
);
  import rdbk_pkg::*;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [OCC_W-1:0] occ;
  logic             ovfl;
  logic             isEmpty, isFull, doPop, doPush, dropPush;
  outSel_t          sel;

  assign isEmpty  = (occ == '0);
  assign isFull   = (occ == FULL_OCC);
  assign doPop    = rdStrobe && (rdAddr == 3'd1) && fifoEn && !isEmpty;
  assign doPush   = pushValid && fifoEn && (!isFull || doPop);
  assign dropPush = pushValid && fifoEn && isFull && !doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || !fifoEn) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
      ovfl  <= 1'b0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
      if (dropPush) ovfl <= 1'b1;
    end
  end

  always_comb begin
    case (rdAddr)
      3'd0:    sel = SEL_STAT0;
      3'd1:    sel = SEL_STAT1;
      3'd2:    sel = SEL_VEC;
      3'd3:    sel = SEL_PEND;
      3'd4:    sel = extReadEn ? SEL_WR4 : SEL_STAT0;
      3'd5:    sel = extReadEn ? SEL_WR5 : SEL_STAT1;
      3'd6:    sel = fifoEn ? SEL_CNT_LO : SEL_VEC;
      default: sel = fifoEn ? SEL_CNT_HI : SEL_PEND;
    endcase
  end

  always_comb begin
    strb.loadOut   = rdStrobe;
    strb.sel       = sel;
    strb.useChanB  = chanSel;
    strb.wrEn      = doPush;
    strb.wrIdx     = IDX_W'(wrPtr);
    strb.rdIdx     = IDX_W'(rdPtr);
    strb.headValid = !isEmpty;
    strb.ovfl      = ovfl;
  end

  // R9: occupancy never passes the configured depth
  assert_occ_bound_R9: assert property (@(posedge clk) disable iff (rst)
    occ <= FULL_OCC);

  // R9: overflow stays set while the queue remains enabled
  assert_ovfl_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (fifoEn && ovfl) |=> ovfl);

  // R10: disabling flushes entries and overflow
  assert_disable_flush_R10: assert property (@(posedge clk) disable iff (rst)
    !fifoEn |=> (occ == '0) && !ovfl);

  // R8: reads of the count locations never retire an entry
  assert_peek_no_pop_R8: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe && rdAddr[2:1] == 2'b11 && !pushValid && fifoEn) |=> occ == $past(occ));

endmodule

// File: rtl/rdbk_datapath.sv
module rdbk_datapath #(
  parameter int DEPTH = 10,
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  rdbk_pkg::strobe_t strb,
  input  logic [7:0]        stat0A,
  input  logic [7:0]        stat0B,
  input  logic [7:0]        stat1A,
  input  logic [7:0]        stat1B,
  input  logic [7:0]        vecA,
  input  logic [7:0]        vecB,
  input  logic [7:0]        wr4A,
  input  logic [7:0]        wr4B,
  input  logic [7:0]        wr5A,
  input  logic [7:0]        wr5B,
  input  logic [5:0]        irqPend,
  input  logic [CNT_W-1:0]  pushCount,
  output logic [7:0]        rdData
);
  import rdbk_pkg::*;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0] countMem [DEPTH];
  logic [CNT_W-1:0] headCnt;
  logic [5:0]       hiBits;
  logic [7:0]       pendByte;
  logic [7:0]       nextData;

  always_ff @(posedge clk) begin
    if (strb.wrEn) countMem[strb.wrIdx[PTR_W-1:0]] <= pushCount;
  end

  assign headCnt  = strb.headValid ? countMem[strb.rdIdx[PTR_W-1:0]] : '0;
  assign hiBits   = 6'(headCnt >> 8);
  assign pendByte = strb.useChanB ? 8'h00 : {2'b00, irqPend};

  always_comb begin
    case (strb.sel)
      SEL_STAT0:  nextData = strb.useChanB ? stat0B : stat0A;
      SEL_STAT1:  nextData = strb.useChanB ? stat1B : stat1A;
      SEL_VEC:    nextData = strb.useChanB ? vecB : vecA;
      SEL_PEND:   nextData = pendByte;
      SEL_WR4:    nextData = strb.useChanB ? wr4B : wr4A;
      SEL_WR5:    nextData = strb.useChanB ? wr5B : wr5A;
      SEL_CNT_LO: nextData = headCnt[7:0];
      default:    nextData = {strb.ovfl, strb.headValid, hiBits};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)               rdData <= 8'h00;
    else if (strb.loadOut) rdData <= nextData;
  end

  // R2: output holds without a strobe
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !strb.loadOut |=> $stable(rdData));

  // R3: pending summary reads zero through channel B
  assert_pend_chanb_R3: assert property (@(posedge clk) disable iff (rst)
    (strb.loadOut && strb.sel == SEL_PEND && strb.useChanB) |=> rdData == 8'h00);

  // R3: top two bits of the pending summary are always zero
  assert_pend_top_R3: assert property (@(posedge clk) disable iff (rst)
    (strb.loadOut && strb.sel == SEL_PEND) |=> rdData[7:6] == 2'b00);

  // R11: empty queue gives zero count and no data-available
  assert_empty_hi_R11: assert property (@(posedge clk) disable iff (rst)
    (strb.loadOut && strb.sel == SEL_CNT_HI && !strb.headValid) |=> rdData[6:0] == 7'h00);

endmodule

// File: rtl/serial_status_readback.sv
module serial_status_readback #(
  parameter int DEPTH = 10,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rdStrobe,
  input  logic             chanSel,
  input  logic [2:0]       rdAddr,
  input  logic             extReadEn,
  input  logic             fifoEn,
  input  logic [7:0]       stat0A,
  input  logic [7:0]       stat0B,
  input  logic [7:0]       stat1A,
  input  logic [7:0]       stat1B,
  input  logic [7:0]       vecA,
  input  logic [7:0]       vecB,
  input  logic [7:0]       wr4A,
  input  logic [7:0]       wr4B,
  input  logic [7:0]       wr5A,
  input  logic [7:0]       wr5B,
  input  logic [5:0]       irqPend,
  input  logic             pushValid,
  input  logic [CNT_W-1:0] pushCount,
  output logic [7:0]       rdData
);
  rdbk_pkg::strobe_t strb;

  rdbk_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .rdStrobe  (rdStrobe),
    .chanSel   (chanSel),
    .rdAddr    (rdAddr),
    .extReadEn (extReadEn),
    .fifoEn    (fifoEn),
    .pushValid (pushValid),
    .strb      (strb)
  );

  rdbk_datapath #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .stat0A    (stat0A),
    .stat0B    (stat0B),
    .stat1A    (stat1A),
    .stat1B    (stat1B),
    .vecA      (vecA),
    .vecB      (vecB),
    .wr4A      (wr4A),
    .wr4B      (wr4B),
    .wr5A      (wr5A),
    .wr5B      (wr5B),
    .irqPend   (irqPend),
    .pushCount (pushCount),
    .rdData    (rdData)
  );

endmodule

// File: tb/test_serial_status_readback.sv
module test_serial_status_readback;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int CNT_W = 14;

  logic clk = 0, rst = 1, rdStrobe = 0, chanSel = 0, extReadEn = 0, fifoEn = 0;
  logic [2:0] rdAddr = 0;
  logic [7:0] stat0A = 0, stat0B = 0, stat1A = 0, stat1B = 0, vecA = 0, vecB = 0;
  logic [7:0] wr4A = 0, wr4B = 0, wr5A = 0, wr5B = 0;
  logic [5:0] irqPend = 0;
  logic pushValid = 0;
  logic [CNT_W-1:0] pushCount = 0;
  logic [7:0] rdData;

  int total = 0, bad = 0;
  bit doneFlag = 0;
  int q[$];
  bit mOvfl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_status_readback #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_serial_status_readback (
    .clk(clk), .rst(rst), .rdStrobe(rdStrobe), .chanSel(chanSel), .rdAddr(rdAddr),
    .extReadEn(extReadEn), .fifoEn(fifoEn), .stat0A(stat0A), .stat0B(stat0B),
    .stat1A(stat1A), .stat1B(stat1B), .vecA(vecA), .vecB(vecB), .wr4A(wr4A),
    .wr4B(wr4B), .wr5A(wr5A), .wr5B(wr5B), .irqPend(irqPend), .pushValid(pushValid),
    .pushCount(pushCount), .rdData(rdData));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expVal(input bit ch, input int a);
    int head;
    logic [7:0] r0, r1, r2, r3;
    head = (q.size() > 0) ? q[0] : 0;
    r0 = ch ? stat0B : stat0A;
    r1 = ch ? stat1B : stat1A;
    r2 = ch ? vecB : vecA;
    r3 = ch ? 8'h00 : {2'b00, irqPend};
    case (a)
      0: return r0;
      1: return r1;
      2: return r2;
      3: return r3;
      4: return extReadEn ? (ch ? wr4B : wr4A) : r0;
      5: return extReadEn ? (ch ? wr5B : wr5A) : r1;
      6: return fifoEn ? 8'(head & 8'hFF) : r2;
      default: return fifoEn ? {mOvfl, q.size() > 0, 6'((head >> 8) & 6'h3F)} : r3;
    endcase
  endfunction

  task automatic rd(input bit ch, input int a, output logic [7:0] d);
    @(negedge clk);
    chanSel = ch; rdAddr = 3'(a); rdStrobe = 1;
    @(negedge clk);
    rdStrobe = 0;
    d = rdData;
    if (a == 1 && fifoEn && q.size() > 0) void'(q.pop_front());
  endtask

  task automatic rdChk(input string req, input bit ch, input int a);
    logic [7:0] e, d;
    e = expVal(ch, a);
    rd(ch, a, d);
    chk(req, d, e);
  endtask

  task automatic push(input int cnt);
    @(negedge clk);
    pushValid = 1; pushCount = CNT_W'(cnt);
    @(negedge clk);
    pushValid = 0;
    if (fifoEn) begin
      if (q.size() < DEPTH) q.push_back(cnt & 14'h3FFF);
      else mOvfl = 1;
    end
  endtask

  task automatic setEn(input bit en);
    @(negedge clk);
    fifoEn = en;
    @(negedge clk);
    if (!en) begin q.delete(); mOvfl = 0; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, keep;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reset rdData", rdData, 8'h00);
    fifoEn = 1;
    @(negedge clk);
    rdChk("R1 R11 empty after reset", 0, 7);
    rdChk("R11 empty low count", 0, 6);

    // sweep all selectors
    for (int pass = 0; pass < 3; pass++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        setEn(cfg[1]);
        extReadEn = cfg[0];
        stat0A = 8'(17*cfg + 3 + pass); stat0B = 8'(29*cfg + 5);
        stat1A = 8'(37*cfg + 7); stat1B = 8'(41*cfg + 11 + pass);
        vecA = 8'(53*cfg + 13); vecB = 8'(59*cfg + 17);
        wr4A = 8'(61*cfg + 19); wr4B = 8'(67*cfg + 23 + pass);
        wr5A = 8'(71*cfg + 29); wr5B = 8'(73*cfg + 31);
        irqPend = 6'(cfg*13 + pass*7 + 1);
        if (cfg[1]) begin
          push(1000*cfg + 77 + pass);
          push(16383 - 311*cfg);
          push(256*cfg + 5);
        end
        for (int ch = 0; ch < 2; ch++)
          for (int a = 0; a < 8; a++)
            rdChk($sformatf("R3 R4 R5 R6 R7 R8 sweep ch=%0d a=%0d ext=%0d en=%0d", ch, a, cfg[0], cfg[1]), ch[0], a);
      end
    end

    // R2: output holds without strobe
    setEn(1);
    irqPend = 6'h2A;
    rd(0, 3, keep);
    chk("R3 pending mapping", keep, 8'h2A);
    @(negedge clk);
    irqPend = 6'h15; rdAddr = 0; chanSel = 1; stat0B = 8'hEE;
    repeat (3) @(negedge clk);
    chk("R2 hold without strobe", rdData, keep);

    // R9 overflow and order
    for (int k = 0; k < 5; k++) push(2000 + 3001*k);
    rdChk("R9 overflow set", 0, 7);
    chk("R9 overflow bit", rdData[7], 1'b1);
    for (int k = 0; k < 4; k++) begin
      rdChk("R8 order hi", 1, 7);
      rdChk("R8 order lo", 0, 6);
      rdChk("R8 pop read", 0, 1);
    end
    rdChk("R9 R11 overflow sticky, empty", 0, 7);
    chk("R11 data-available clear", rdData[6], 1'b0);

    // R12 simultaneous push and pop on full
    setEn(0);
    setEn(1);
    for (int k = 0; k < 4; k++) push(100*k + 300);
    @(negedge clk);
    chanSel = 0; rdAddr = 1; rdStrobe = 1; pushValid = 1; pushCount = 14'h2ABC;
    @(negedge clk);
    rdStrobe = 0; pushValid = 0;
    void'(q.pop_front()); q.push_back(14'h2ABC);
    rdChk("R12 no overflow on push+pop", 0, 7);
    chk("R12 overflow bit clear", rdData[7], 1'b0);
    for (int k = 0; k < 4; k++) begin
      rdChk("R12 drain lo", 0, 6);
      rdChk("R12 drain pop", 0, 1);
    end

    // R10 disable flushes, pushes ignored
    for (int k = 0; k < 5; k++) push(40 + k);
    setEn(0);
    push(999);
    rdChk("R10 disabled alias", 0, 7);
    setEn(1);
    rdChk("R10 flushed after re-enable", 0, 7);
    chk("R10 overflow cleared", rdData, 8'h00);

    // R1 reset mid-run
    push(1234);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    q.delete(); mOvfl = 0;
    chk("R1 reset clears output", rdData, 8'h00);
    rdChk("R1 reset empties queue", 0, 7);

    doneFlag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule